// File: doc/BRIEF.md
# Serial Configuration Host Controller

This block lets on-chip logic program a three-wire configuration port through a parallel command interface. A command holds a row number, a data byte and a write flag. The controller takes the command on a valid/ready handshake. It then pulls the enable line low and shifts an 18-bit frame out on the data line, with one rising edge of the serial clock for each bit. When the frame is complete it returns the enable line high, which commits the row in the remote device.

For a read, the controller sends the same frame with the write flag cleared. It then issues eight more serial clock pulses and captures the remote device's reply from the scan input, least significant bit first. The serial clock is made by counting system clock cycles. Separate parameters set the data setup time before each rising edge, the high time of the clock, the data hold time after the falling edge, and the low guard time before the enable line rises. Each of these counts must be at least 1.

Top module: `cfg_serial_host`

## Requirements
- R1: In reset and while idle, ser_en_o is 1, ser_clk_o is 0, ser_data_o is 0 and done_o is 0.
- R2: A command is taken on the first rising edge at which cmd_valid_i and cmd_ready_o are both 1. From the next cycle, ser_en_o stays 0 until the whole frame and the guard have been sent. It then returns to 1 for two cycles before the controller goes idle.
- R3: The frame bit k is on ser_data_o during the k-th serial clock pulse, counting from 0. Bits 0-7 hold the data byte, LSB first. Bits 8-13 hold the row, LSB first, with the row zero-extended from ROW_W bits. Bit 14 is 1 for a write and 0 for a read. Bits 15-17 are all 1.
- R4: Each bit is driven for SETUP_CYC cycles with ser_clk_o low before the clock rises. ser_clk_o is then high for CLK_HI_CYC cycles. The same bit stays on ser_data_o for HOLD_CYC cycles after the clock falls.
- R5: After the last hold time, ser_clk_o and ser_data_o stay 0 for GUARD_CYC cycles with ser_en_o still 0, and only then does ser_en_o rise.
- R6: cmd_ready_o is 1 only while idle. cmd_valid_i and the command fields have no effect while a transaction is in progress.
- R7: done_o is a single-cycle pulse in the second cycle of ser_en_o high, which is one cycle after ENABLE returns high.
- R8: A read issues 8 further serial clock pulses after bit 17, with ser_data_o 0. ser_scan_i is sampled in the last high cycle of each of these pulses, and the first sample is result bit 0. The byte is on rdata_o when done_o pulses.
- R9: A write clears rdata_o to 0 by the time done_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Controller idle and able to take a command |
| cmd_row_i | input | ROW_W | Target row number |
| cmd_wdata_i | input | 8 | Byte to write (ignored in content for reads, still shifted) |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| ser_en_o | output | 1 | Serial enable, low during a frame |
| ser_clk_o | output | 1 | Serial clock |
| ser_data_o | output | 1 | Serial data out |
| ser_scan_i | input | 1 | Serial readback from the remote device |
| done_o | output | 1 | Transaction complete pulse |
| rdata_o | output | 8 | Readback byte, valid with done_o |

## Verification
The hardest case is a readback byte that arrives on the scan line only after the remote device has seen the 19th clock edge. It must be sampled in the exact cycle before the clock falls. The bench emulates the remote device. It counts the rising edges of the serial clock and changes ser_scan_i right after each edge, so a one-cycle error in the sample point gives a wrong byte. A second hard case is a command offered while the controller is busy. The bench keeps cmd_valid_i high with unrelated fields throughout some transactions and checks every output against its reference cycle by cycle.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int BYTE_W     = 8;
  localparam int ROW_FIELD  = 6;
  localparam int FRAME_BITS = 18;
  localparam int RB_BITS    = 8;
  localparam int ALL_BITS   = FRAME_BITS + RB_BITS;
  localparam int IDX_W      = $clog2(ALL_BITS);
  localparam logic [2:0] CHIP_ID = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_HOLD, ST_GUARD, ST_COMMIT, ST_FIN
  } phase_e;
endpackage

// File: rtl/cfg_frame_pack.sv
module cfg_frame_pack
  import cfg_serial_pkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic                  write_i,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam int PAD_W = ROW_FIELD - ROW_W;

  // vector bit 0 leaves first
  always_comb begin
    frame_o = '0;
    frame_o[BYTE_W-1:0] = wdata_i;
    frame_o[BYTE_W +: ROW_FIELD] = {{PAD_W{1'b0}}, row_i};
    frame_o[BYTE_W+ROW_FIELD] = write_i;
    frame_o[FRAME_BITS-1 -: 3] = CHIP_ID;
  end
endmodule

// File: rtl/cfg_rb_shift.sv
module cfg_rb_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clr_i)   q_o <= '0;
    else if (shift_i) q_o <= {bit_i, q_o[W-1:1]};  // first sample ends in bit 0
  end
endmodule

// File: rtl/cfg_serial_host.sv
module cfg_serial_host
  import cfg_serial_pkg::*;
#(
  parameter int ROW_W      = 4,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 1,
  parameter int CLK_HI_CYC = 2,
  parameter int GUARD_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ROW_W-1:0]  cmd_row_i,
  input  logic [BYTE_W-1:0] cmd_wdata_i,
  input  logic              cmd_write_i,
  output logic              ser_en_o,
  output logic              ser_clk_o,
  output logic              ser_data_o,
  input  logic              ser_scan_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int M1    = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int M2    = (CLK_HI_CYC > GUARD_CYC) ? CLK_HI_CYC : GUARD_CYC;
  localparam int MAXC  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  phase_e                state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] frame_q, frame_w;
  logic                  read_q;
  logic [CNT_W-1:0]      len_m1;
  logic                  phase_end, last_bit, in_frame, accept, rb_shift;

  cfg_frame_pack #(.ROW_W(ROW_W)) u_pack (
    .wdata_i(cmd_wdata_i), .row_i(cmd_row_i), .write_i(cmd_write_i), .frame_o(frame_w)
  );

  always_comb begin
    unique case (state_q)
      ST_SETUP: len_m1 = CNT_W'(SETUP_CYC - 1);
      ST_HIGH:  len_m1 = CNT_W'(CLK_HI_CYC - 1);
      ST_HOLD:  len_m1 = CNT_W'(HOLD_CYC - 1);
      ST_GUARD: len_m1 = CNT_W'(GUARD_CYC - 1);
      default:  len_m1 = '0;
    endcase
  end

  assign phase_end = (cnt_q == len_m1);
  assign last_bit  = read_q ? (idx_q == IDX_W'(ALL_BITS - 1)) : (idx_q == IDX_W'(FRAME_BITS - 1));
  assign in_frame  = (idx_q < IDX_W'(FRAME_BITS));
  assign accept    = (state_q == ST_IDLE) && cmd_valid_i;
  assign rb_shift  = (state_q == ST_HIGH) && phase_end && read_q && !in_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      frame_q <= '0;
      read_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          frame_q <= frame_w;
          read_q  <= !cmd_write_i;
          idx_q   <= '0;
          cnt_q   <= '0;
          state_q <= ST_SETUP;
        end
        ST_SETUP, ST_HIGH, ST_HOLD, ST_GUARD: begin
          if (!phase_end) cnt_q <= cnt_q + 1'b1;
          else begin
            cnt_q <= '0;
            unique case (state_q)
              ST_SETUP: state_q <= ST_HIGH;
              ST_HIGH:  state_q <= ST_HOLD;
              ST_HOLD:
                if (last_bit) state_q <= ST_GUARD;
                else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_SETUP;
                end
              default:  state_q <= ST_COMMIT;
            endcase
          end
        end
        ST_COMMIT: state_q <= ST_FIN;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  cfg_rb_shift #(.W(BYTE_W)) u_rb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .shift_i(rb_shift),
    .bit_i(ser_scan_i), .q_o(rdata_o)
  );

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign ser_en_o    = (state_q == ST_IDLE) || (state_q == ST_COMMIT) || (state_q == ST_FIN);
  assign ser_clk_o   = (state_q == ST_HIGH);
  assign ser_data_o  = ((state_q == ST_SETUP) || (state_q == ST_HIGH) || (state_q == ST_HOLD))
                       && in_frame && frame_q[idx_q];
  assign done_o      = (state_q == ST_FIN);

  // R4: data settles before the clock rises and holds past its fall
  a_r4_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_clk_o) |-> $stable(ser_data_o));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_clk_o) |-> $stable(ser_data_o));
  // R5: clock already low for a cycle when enable rises
  a_r5_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_en_o) |-> (!ser_clk_o && !$past(ser_clk_o)));
  // R6: handshake only while the port is quiet
  a_r6_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (ser_en_o && !ser_clk_o));
  // R7: done follows a cycle of enable high and lasts one cycle
  a_r7_done_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ser_en_o && $past(ser_en_o) && !$past(done_o)));
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2: a frame never opens without a command
  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_en_o) |-> $past(cmd_valid_i));
endmodule

// File: tb/tb_cfg_serial_host.sv
module tb_cfg_serial_host;
  localparam int ROW_W = 4, SU = 2, HO = 1, HI = 2, GU = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, wr = 1'b0, scan = 1'b0;
  logic [ROW_W-1:0] row = '0;
  logic [7:0] wdata = '0;
  logic ready, en, sclk, sdata, done;
  logic [7:0] rdata;

  always #5 clk = ~clk;

  cfg_serial_host #(.ROW_W(ROW_W), .SETUP_CYC(SU), .HOLD_CYC(HO), .CLK_HI_CYC(HI), .GUARD_CYC(GU)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_row_i(row), .cmd_wdata_i(wdata), .cmd_write_i(wr),
    .ser_en_o(en), .ser_clk_o(sclk), .ser_data_o(sdata), .ser_scan_i(scan),
    .done_o(done), .rdata_o(rdata)
  );

  int errors = 0, checks = 0, cycles = 0;
  // entry: {phase[2:0], en, clk, data, done}
  logic [6:0] exp_q[$];
  logic [7:0] exp_rdata = '0;
  logic [7:0] rb_byte = '0;
  logic req_pend = 1'b0, req_wr = 1'b0, spam = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [7:0] req_data = '0;
  int rises = 0;
  logic prev_clk = 1'b0;

  function automatic string tag_of(input logic [2:0] ph);
    case (ph)
      3'd0: return "R1";
      3'd1: return "R4";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R2";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string t, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", t, what, act, expv, cycles);
    end
  endtask

  task automatic push_txn(input logic [ROW_W-1:0] r, input logic [7:0] d, input logic w);
    int nb = w ? 18 : 26;
    for (int k = 0; k < nb; k++) begin
      logic b;
      logic [2:0] ph_hi;
      if (k < 8) b = d[k];
      else if (k < 8 + ROW_W) b = r[k-8];
      else if (k < 14) b = 1'b0;
      else if (k == 14) b = w;
      else if (k < 18) b = 1'b1;
      else b = 1'b0;
      ph_hi = (k >= 18) ? 3'd7 : 3'd2;   // readback pulses tagged R8
      for (int i = 0; i < SU; i++) exp_q.push_back({3'd1, 1'b0, 1'b0, b, 1'b0});
      for (int i = 0; i < HI; i++) exp_q.push_back({ph_hi, 1'b0, 1'b1, b, 1'b0});
      for (int i = 0; i < HO; i++) exp_q.push_back({3'd3, 1'b0, 1'b0, b, 1'b0});
    end
    for (int i = 0; i < GU; i++) exp_q.push_back({3'd4, 4'b0000});
    exp_q.push_back({3'd5, 4'b1000});
    exp_q.push_back({3'd6, 4'b1001});
    exp_rdata = w ? 8'h00 : rb_byte;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      chk("R1", en, 1'b1, "enable in reset");
      chk("R1", sclk, 1'b0, "clock in reset");
      chk("R1", sdata, 1'b0, "data in reset");
      chk("R1", done, 1'b0, "done in reset");
    end else begin
      if (exp_q.size() != 0) begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_of(e[6:4]);
        chk("R2", en, e[3], "enable");
        chk(t, sclk, e[2], "serial clock");
        chk(t, sdata, e[1], "serial data");
        chk("R7", done, e[0], "done");
        chk("R6", ready, 1'b0, "ready while busy");
        if (e[0]) begin
          checks++;
          if (rdata !== exp_rdata) begin
            errors++;
            $display("FAIL %s rdata: actual=%02h expected=%02h", exp_rdata == 8'h00 && req_wr ? "R9" : "R8",
                     rdata, exp_rdata);
          end
        end
      end else begin
        chk("R1", en, 1'b1, "idle enable");
        chk("R1", sclk, 1'b0, "idle clock");
        chk("R1", sdata, 1'b0, "idle data");
        chk("R1", done, 1'b0, "idle done");
        chk("R6", ready, 1'b1, "idle ready");
      end
      // remote device: shifts its byte out after the 19th rising edge
      if (en) rises = 0;
      else if (sclk && !prev_clk) rises++;
      prev_clk = sclk;
      scan = (rises >= 19 && rises <= 26) ? rb_byte[rises-19] : 1'b0;
      // stimulus
      if (exp_q.size() == 0 && req_pend) begin
        valid = 1'b1; row = req_row; wdata = req_data; wr = req_wr;
        push_txn(req_row, req_data, req_wr);
        req_pend = 1'b0;
      end else if (spam && exp_q.size() > 2) begin
        valid = 1'b1; row = ~row; wdata = wdata + 8'h37; wr = ~wr;
      end else valid = 1'b0;
    end
  end

  task automatic cmd(input logic [ROW_W-1:0] r, input logic [7:0] d, input logic w,
                     input logic [7:0] rb, input logic sp);
    rb_byte = rb; spam = sp;
    req_row = r; req_data = d; req_wr = w; req_pend = 1'b1;
    @(posedge clk);
    while (req_pend || exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    cmd(4'd5,  8'hA5, 1'b1, 8'h00, 1'b0);  // R3 write pattern
    cmd(4'd15, 8'h00, 1'b1, 8'h00, 1'b0);  // R3 all row bits set
    cmd(4'd0,  8'hFF, 1'b1, 8'h00, 1'b0);  // R3 zero row
    cmd(4'd3,  8'h5A, 1'b0, 8'h3C, 1'b0);  // R8 read
    cmd(4'd9,  8'h12, 1'b0, 8'h81, 1'b1);  // R8 + R6 valid held during busy
    cmd(4'd6,  8'hC3, 1'b1, 8'h00, 1'b1);  // R9 + R6 write clears result
    cmd(4'd10, 8'h00, 1'b0, 8'hFE, 1'b0);  // R8 edge byte
    repeat (5) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule